// File: doc/BRIEF.md
# Windowed Repeated-Bit Run Detector

This block examines one packet word for a stretch of adjacent bits that all hold the same value. It is long enough to be worth replacing by a start marker, a length field and an end marker on a serial link. The search covers only the upper part of the word. A parameter sets how many low-order bits stay outside the search; by default the lowest byte is left out, so that byte can go out on the link while the rest is still being scanned.

Each bit in the searched region is compared with the bit below it by an XOR. The comparators form windows of eight. Each window tracks the run length at every bit position, taking the count that arrives from the window below. It offers its best run that ends inside the window. A stapling stage picks among the window candidates. A run that crosses window edges is therefore reported once, as a whole.

The result is registered one clock after the packet strobe as a start index, a length and a valid flag. The qualifying threshold and the tie policy are parameters.

Top module: `run_detect`

## Requirements
- R1: While reset is asserted, and after reset until the first packet strobe, `desc_valid`, `desc_index` and `desc_length` are all zero.
- R2: The descriptor for a packet applied with `pkt_valid` high at a rising clock edge appears on the outputs after that edge. In any cycle that follows an edge where `pkt_valid` was low, `desc_valid` is 0.
- R3: A run qualifies only if it holds at least MIN_RUN (default 8) adjacent equal bits. A run of exactly 8 qualifies; a run of 7 does not.
- R4: Bits below position SKIP (default 8) never belong to a run. A run that reaches below bit 8 is counted from bit 8 upward, with index 8.
- R5: When more than one run qualifies, the longest one is reported.
- R6: When qualifying runs tie in length, the one with the lowest start index is reported (default tie policy).
- R7: A run that crosses one or more window boundaries (bits 15/16 and 23/24 by default) is reported as a single run with its full length.
- R8: When no run qualifies, `desc_valid` is 0 and `desc_index` and `desc_length` are 0.
- R9: `desc_index` is the lowest bit position of the run and `desc_length` is its bit count. Runs of zeros and runs of ones are treated alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | Packet strobe; `pkt_data` is sampled when high |
| pkt_data | input | PKT_W (32) | Packet word, bit 0 is the lowest position |
| desc_valid | output | 1 | A qualifying run was found in the last strobed packet |
| desc_index | output | $clog2(PKT_W) (5) | Lowest bit position of the reported run |
| desc_length | output | $clog2(PKT_W-SKIP+1) (5) | Number of bits in the reported run |

## Verification
The properties take for granted that `pkt_data` holds known values in every cycle where `pkt_valid` is high. The run-uniformity property reads the packet of the previous cycle, so an unknown bit there would make it fail. They also assume reset is asserted before the first strobe. The stimulus sets both inputs to zero at time zero and holds reset for several cycles. Inputs change only on falling clock edges, so each value is stable across the rising edge that samples it.

// File: rtl/rd_pkg.sv
package rd_pkg;

   // Which of two equally long runs wins the selection.
   typedef enum logic {
      TIE_LOW_INDEX  = 1'b0,
      TIE_HIGH_INDEX = 1'b1
   } tie_pol_e;

   // Candidates are always visited in ascending bit order, so the tie
   // policy reduces to strict versus non-strict comparison.
   function automatic logic beats(input int unsigned cand,
                                  input int unsigned best,
                                  input tie_pol_e    pol);
      return (pol == TIE_LOW_INDEX) ? (cand > best) : (cand >= best);
   endfunction

endpackage

// File: rtl/rd_scan_window.sv
module rd_scan_window
   import rd_pkg::*;
#(
   parameter int       WIN   = 8,
   parameter int       BASE  = 8,
   parameter int       IDX_W = 5,
   parameter int       LEN_W = 5,
   parameter bit       FIRST = 1'b0,
   parameter bit       LAST  = 1'b0,
   parameter tie_pol_e TIE   = TIE_LOW_INDEX
) (
   input  logic [WIN-1:0]   win_bits,
   input  logic             prev_bit,
   input  logic             next_bit,
   input  logic [LEN_W-1:0] carry_in,
   output logic [LEN_W-1:0] carry_out,
   output logic [LEN_W-1:0] cand_len,
   output logic [IDX_W-1:0] cand_idx
);

   logic [WIN-1:0]            same_prev;
   logic [WIN-1:0]            run_ends;
   logic [WIN-1:0][LEN_W-1:0] run_len;

   // One XOR per bit: a zero XOR result means the bit repeats its neighbour.
   for (genvar k = 0; k < WIN; k++) begin : g_cmp
      if (k == 0) begin : g_head
         assign same_prev[k] = FIRST ? 1'b0 : ~(win_bits[k] ^ prev_bit);
      end else begin : g_body
         assign same_prev[k] = ~(win_bits[k] ^ win_bits[k-1]);
      end
      if (k == WIN-1) begin : g_tail
         assign run_ends[k] = LAST ? 1'b1 : (win_bits[k] ^ next_bit);
      end else begin : g_mid
         assign run_ends[k] = ~same_prev[k+1];
      end
   end

   // Run length ending at each bit, seeded by the count from below.
   always_comb begin
      logic [LEN_W-1:0] acc;
      acc = carry_in;
      for (int k = 0; k < WIN; k++) begin
         run_len[k] = same_prev[k] ? (acc + LEN_W'(1)) : LEN_W'(1);
         acc        = run_len[k];
      end
   end

   assign carry_out = run_len[WIN-1];

   // Best run that terminates inside this window.
   always_comb begin
      cand_len = '0;
      cand_idx = '0;
      for (int k = 0; k < WIN; k++) begin
         if (run_ends[k] && beats(32'(run_len[k]), 32'(cand_len), TIE)) begin
            cand_len = run_len[k];
            cand_idx = IDX_W'(BASE + k + 1 - int'(run_len[k]));
         end
      end
   end

endmodule

// File: rtl/rd_stapler.sv
module rd_stapler
   import rd_pkg::*;
#(
   parameter int       NWIN  = 3,
   parameter int       IDX_W = 5,
   parameter int       LEN_W = 5,
   parameter tie_pol_e TIE   = TIE_LOW_INDEX
) (
   input  logic [NWIN-1:0][LEN_W-1:0] win_len,
   input  logic [NWIN-1:0][IDX_W-1:0] win_idx,
   output logic [LEN_W-1:0]           best_len,
   output logic [IDX_W-1:0]           best_idx
);

   // Window candidates already hold whole runs (lengths carried across
   // edges), so the final pick is an ordered reduction.
   always_comb begin
      best_len = '0;
      best_idx = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (beats(32'(win_len[w]), 32'(best_len), TIE)) begin
            best_len = win_len[w];
            best_idx = win_idx[w];
         end
      end
   end

endmodule

// File: rtl/run_detect.sv
module run_detect
   import rd_pkg::*;
#(
   parameter int       PKT_W   = 32,
   parameter int       WIN     = 8,
   parameter int       SKIP    = 8,
   parameter int       MIN_RUN = 8,
   parameter tie_pol_e TIE     = TIE_LOW_INDEX,
   localparam int      IDX_W   = $clog2(PKT_W),
   localparam int      LEN_W   = $clog2(PKT_W - SKIP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic [PKT_W-1:0] pkt_data,
   output logic             desc_valid,
   output logic [IDX_W-1:0] desc_index,
   output logic [LEN_W-1:0] desc_length
);

   localparam int REGION = PKT_W - SKIP;
   localparam int NWIN   = REGION / WIN;

   // Elaboration-time parameter checks
   if (WIN < 1 || SKIP < 0 || SKIP >= PKT_W) begin : g_bad_geom
      $error("run_detect: WIN must be positive and SKIP inside the packet");
   end
   if ((REGION % WIN) != 0) begin : g_bad_win
      $error("run_detect: searched region must be a whole number of windows");
   end
   if (MIN_RUN < 1 || MIN_RUN > REGION) begin : g_bad_min
      $error("run_detect: MIN_RUN must lie within the searched region");
   end

   if (SKIP > 0) begin : g_low
      logic unused_low_bits;
      assign unused_low_bits = ^pkt_data[SKIP-1:0];
   end

   logic [NWIN-1:0][LEN_W-1:0] chain;
   logic [NWIN-1:0][LEN_W-1:0] w_len;
   logic [NWIN-1:0][IDX_W-1:0] w_idx;
   logic [LEN_W-1:0]           best_len;
   logic [IDX_W-1:0]           best_idx;
   logic                       hit;

   assign chain[0] = '0;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam int BASE = SKIP + w * WIN;
      logic             prev_b;
      logic             next_b;
      logic [LEN_W-1:0] carry_fwd_or_unused;

      if (w == 0) begin : g_p0
         assign prev_b = 1'b0;
      end else begin : g_pn
         assign prev_b = pkt_data[BASE-1];
      end
      if (w == NWIN-1) begin : g_nl
         assign next_b = 1'b0;
      end else begin : g_nn
         assign next_b = pkt_data[BASE+WIN];
         assign chain[w+1] = carry_fwd_or_unused;
      end

      rd_scan_window #(
         .WIN   (WIN),
         .BASE  (BASE),
         .IDX_W (IDX_W),
         .LEN_W (LEN_W),
         .FIRST (w == 0),
         .LAST  (w == NWIN-1),
         .TIE   (TIE)
      ) u_win (
         .win_bits  (pkt_data[BASE +: WIN]),
         .prev_bit  (prev_b),
         .next_bit  (next_b),
         .carry_in  (chain[w]),
         .carry_out (carry_fwd_or_unused),
         .cand_len  (w_len[w]),
         .cand_idx  (w_idx[w])
      );
   end

   rd_stapler #(
      .NWIN  (NWIN),
      .IDX_W (IDX_W),
      .LEN_W (LEN_W),
      .TIE   (TIE)
   ) u_stapler (
      .win_len  (w_len),
      .win_idx  (w_idx),
      .best_len (best_len),
      .best_idx (best_idx)
   );

   assign hit = (32'(best_len) >= MIN_RUN);

   // Sequence registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_valid  <= 1'b0;
         desc_index  <= '0;
         desc_length <= '0;
      end else if (pkt_valid && hit) begin
         desc_valid  <= 1'b1;
         desc_index  <= best_idx;
         desc_length <= best_len;
      end else begin
         desc_valid  <= 1'b0;
         desc_index  <= '0;
         desc_length <= '0;
      end
   end

   // ---------------- assertions ----------------
   function automatic logic run_is_uniform(input logic [PKT_W-1:0] pkt,
                                           input logic [IDX_W-1:0] idx,
                                           input logic [LEN_W-1:0] len);
      logic ok;
      ok = 1'b1;
      for (int b = 0; b < PKT_W; b++) begin
         if (b >= int'(idx) && b < int'(idx) + int'(len) && pkt[b] != pkt[idx])
            ok = 1'b0;
      end
      return ok;
   endfunction

   // R2: a descriptor only follows a strobed packet
   p_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(pkt_valid));

   // R3: reported runs meet the threshold
   p_min_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (32'(desc_length) >= MIN_RUN));

   // R4: excluded low bits are never the start of a run
   p_skip_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (32'(desc_index) >= SKIP));

   // R8: idle descriptor is all zero
   p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_valid |-> (desc_index == '0 && desc_length == '0));

   // R9: run fits in the packet and covers equal bits only
   p_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (32'(desc_index) + 32'(desc_length) <= PKT_W));

   p_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> run_is_uniform($past(pkt_data), desc_index, desc_length));

endmodule

// File: tb/sim_run_detect.sv
module sim_run_detect;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [31:0] pkt_data = '0;
   logic        desc_valid;
   logic [4:0]  desc_index;
   logic [4:0]  desc_length;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   run_detect u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (pkt_valid),
      .pkt_data    (pkt_data),
      .desc_valid  (desc_valid),
      .desc_index  (desc_index),
      .desc_length (desc_length)
   );

   // Expected result from the requirements: longest run inside bits 8..31,
   // at least 8 long, lowest start on a tie.
   function automatic void ref_best(input logic [31:0] d, output bit v,
                                    output int i, output int l);
      int bl = 0;
      int bi = 0;
      for (int s = 8; s < 32; s++) begin
         if (s == 8 || d[s] != d[s-1]) begin
            int n = 0;
            while (s + n < 32 && d[s+n] == d[s]) n++;
            if (n > bl) begin
               bl = n;
               bi = s;
            end
         end
      end
      v = (bl >= 8);
      i = v ? bi : 0;
      l = v ? bl : 0;
   endfunction

   task automatic check(input string req, input bit ev, input int ei, input int el);
      checks++;
      if (desc_valid !== ev || int'(desc_index) != ei || int'(desc_length) != el) begin
         failures++;
         $display("FAIL %s: got valid=%0b idx=%0d len=%0d, expected valid=%0b idx=%0d len=%0d",
                  req, desc_valid, desc_index, desc_length, ev, ei, el);
      end
   endtask

   // Drive at the falling edge, check at the next falling edge.
   task automatic apply(input logic [31:0] d, input string req);
      bit v;
      int i;
      int l;
      pkt_valid = 1'b1;
      pkt_data  = d;
      @(posedge clk);
      @(negedge clk);
      ref_best(d, v, i, l);
      check(req, v, i, l);
   endtask

   task automatic go_idle(input string req);
      pkt_valid = 1'b0;
      pkt_data  = $urandom;
      @(posedge clk);
      @(negedge clk);
      check(req, 1'b0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got no end, expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20061));
      // R1: reset state, strobe held during reset has no effect
      repeat (2) @(negedge clk);
      pkt_valid = 1'b1;
      pkt_data  = 32'h0;
      repeat (2) @(negedge clk);
      check("R1 during reset", 1'b0, 0, 0);
      pkt_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, 0, 0);

      // R9: polarity, index and length
      apply(32'h0000_0000, "R9 all zeros");
      apply(32'hFFFF_FFFF, "R9 all ones");
      apply(32'hFFC0_0FFF, "R9 zero run at 12");
      // R2: descriptor drops after strobe ends
      go_idle("R2 idle after packet");
      go_idle("R2 stays idle");
      // R3: threshold edges
      apply(32'hAAAA_FF00, "R3 exact eight");
      apply(32'hAAAA_7F00, "R3 seven rejected");
      // R4: low byte excluded
      apply(32'hAAAA_AAFF, "R4 low byte ones only");
      apply(32'h5555_55FF, "R4 low ones touching bit 8");
      apply(32'hAAAA_0000, "R4 run clipped at bit 8");
      // R5 / R6
      apply(32'h00FF_FF00, "R5 longest wins");
      apply(32'h00AA_FF00, "R6 tie to lowest index");
      // R7: window crossings
      apply(32'h003F_F000, "R7 crosses 15/16");
      apply(32'h03FF_C000, "R7 crosses two boundaries");
      // R8
      apply(32'h5555_5500, "R8 no run");
      go_idle("R2 idle again");

      // Random packets, half of them with an implanted run
      for (int n = 0; n < 400; n++) begin
         logic [31:0] d;
         d = $urandom;
         if (n % 2 == 0) begin
            int st;
            int ln;
            bit bv;
            st = 8 + int'($urandom % 24);
            ln = 6 + int'($urandom % 14);
            bv = bit'($urandom % 2);
            for (int b = st; b < st + ln && b < 32; b++) d[b] = bv;
         end
         apply(d, "R5 R6 R7 random");
         if (n % 37 == 0) go_idle("R2 random idle");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule